// File: doc/BRIEF.md
# Over-Current Skip-and-Latch Guard

This block protects each channel of a multi-channel synchronous buck controller against sustained overload. It advances once per switching period: a one-clock cycle-start strobe marks the beginning of every period, and at that strobe the block samples a per-channel current-limit flag. The flag comes from a comparator outside this block that holds a sample of low-side switch current.

When the flag is found high in normal operation, the block blocks the high-side drive for that period and for the eight periods that follow. Switching then resumes while the block watches the next eight periods. A second limit hit anywhere in that watch window latches an over-current fault. The latched fault keeps the high-side drive blocked and is meant to force the channel's power-good indication low. If the watch window passes without a hit, the channel returns to normal operation. The only ways out of a latched fault are a low level on the channel enable or a reset, which models a supply cycle.

Each channel runs its own sequence. All channels share the clock, the reset and the cycle-start strobe.

Top module: `ocp_guard`

## Requirements
- R1: In normal operation, a cycle-start strobe that sees `lim_hit[c]` high makes `hs_block[c]` high from the next clock, so the triggering period is already blocked.
- R2: `hs_block[c]` stays high through the eight periods after the triggering one. It falls at the clock following the strobe that begins the ninth period.
- R3: A limit hit during the eight blocked periods is ignored and does not restart the count.
- R4: A limit hit at any strobe that begins periods nine through sixteen (both ends included) sets `oc_latched[c]` from the next clock. While `oc_latched[c]` is high, `hs_block[c]` is high.
- R5: If no hit occurs in periods nine through sixteen, the channel is back in normal operation after the strobe of period sixteen. A hit at the strobe of period seventeen starts a new blocked interval.
- R6: While the channel enable stays high, a latched fault holds regardless of further strobes or limit hits.
- R7: A low `chan_en[c]` clears `oc_latched[c]`, `hs_block[c]` and the period count from the next clock. Strobes are ignored while the enable is low.
- R8: The limit flag is looked at only on a clock where `cyc_start` is high. On other clocks with the enable high, both outputs hold their values.
- R9: Channels are independent: one channel's limit flag and enable have no effect on another channel's outputs.
- R10: While `rst` is high, both outputs of every channel are low from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset (supply cycle) |
| cyc_start | input | 1 | One-clock strobe at the start of each switching period |
| lim_hit | input | NUM_CH | Per-channel held current-limit comparator result |
| chan_en | input | NUM_CH | Per-channel enable; low clears the channel |
| hs_block | output | NUM_CH | High blocks the channel's high-side drive |
| oc_latched | output | NUM_CH | Latched over-current fault, used to pull power-good low |

## Verification
The assertions take the following for granted about the inputs:
- `cyc_start` is a single-clock pulse, several clocks apart from the next one.
- `lim_hit` and `chan_en` are synchronous to `clk`.
- `rst` is asserted from time zero.

The stimulus drives all inputs on the falling clock edge. Strobes are spaced four clocks apart. Between strobes the limit flags are held high on purpose, so any sampling outside a strobe would show up. The enable is dropped both inside a blocked interval and inside a latched fault, and limit hits land on the boundary periods eight, nine, sixteen and seventeen.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        OC_RUN   = 2'd0,
        OC_SKIP  = 2'd1,
        OC_WATCH = 2'd2,
        OC_TRIP  = 2'd3
    } oc_state_e;

    typedef struct packed {
        logic block;
        logic latched;
    } oc_out_t;

    function automatic oc_out_t oc_decode(oc_state_e s);
        oc_out_t o;
        o.block   = (s == OC_SKIP) || (s == OC_TRIP);
        o.latched = (s == OC_TRIP);
        return o;
    endfunction

    function automatic int oc_cnt_width(int last);
        return (last < 2) ? 1 : $clog2(last + 1);
    endfunction

endpackage

// File: rtl/ocp_cyc_count.sv
module ocp_cyc_count #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (adv) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/ocp_chan.sv
module ocp_chan
    import ocp_pkg::*;
#(
    parameter int SKIP_CYC  = 8,
    parameter int WATCH_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic lim_hit,
    input  logic en,
    output logic block,
    output logic latched
);
    localparam int LAST = SKIP_CYC + WATCH_CYC;
    localparam int CW   = oc_cnt_width(LAST);
    localparam logic [CW-1:0] SKIP_L = CW'(SKIP_CYC);
    localparam logic [CW-1:0] LAST_L = CW'(LAST);

    oc_state_e     state, state_n;
    logic [CW-1:0] idx, idx_nxt;
    logic          cnt_clr, cnt_adv, in_window;
    oc_out_t       outs;

    ocp_cyc_count #(.W(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .adv  (cnt_adv),
        .count(idx)
    );

    assign idx_nxt   = idx + 1'b1;
    assign in_window = (state == OC_WATCH) ||
                       ((state == OC_SKIP) && (idx_nxt > SKIP_L));

    always_comb begin
        state_n = state;
        cnt_clr = 1'b0;
        cnt_adv = 1'b0;
        if (!en) begin
            state_n = OC_RUN;
            cnt_clr = 1'b1;
        end else if (cyc_start) begin
            unique case (state)
                OC_RUN: begin
                    if (lim_hit) begin
                        state_n = OC_SKIP;
                        cnt_clr = 1'b1;
                    end
                end
                OC_SKIP, OC_WATCH: begin
                    cnt_adv = 1'b1;
                    if (in_window) begin
                        if (lim_hit) begin
                            state_n = OC_TRIP;
                        end else if (idx_nxt == LAST_L) begin
                            state_n = OC_RUN;
                        end else begin
                            state_n = OC_WATCH;
                        end
                    end
                end
                OC_TRIP: state_n = OC_TRIP;
                default: state_n = OC_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OC_RUN;
        end else begin
            state <= state_n;
        end
    end

    assign outs    = oc_decode(state);
    assign block   = outs.block;
    assign latched = outs.latched;
endmodule

// File: rtl/ocp_guard.sv
module ocp_guard #(
    parameter int NUM_CH    = 2,
    parameter int SKIP_CYC  = 8,
    parameter int WATCH_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic [NUM_CH-1:0] lim_hit,
    input  logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] hs_block,
    output logic [NUM_CH-1:0] oc_latched
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ocp_chan #(
            .SKIP_CYC (SKIP_CYC),
            .WATCH_CYC(WATCH_CYC)
        ) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cyc_start(cyc_start),
            .lim_hit  (lim_hit[c]),
            .en       (chan_en[c]),
            .block    (hs_block[c]),
            .latched  (oc_latched[c])
        );
    end
endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_start,
    input logic [NUM_CH-1:0] lim_hit,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] hs_block,
    input logic [NUM_CH-1:0] oc_latched
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_a
        AST_TRIGGER_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            (chan_en[c] && cyc_start && lim_hit[c] && !hs_block[c]) |=> hs_block[c]); // R1
        AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            oc_latched[c] |-> hs_block[c]); // R4
        AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $rose(oc_latched[c]) |-> $past(cyc_start && lim_hit[c] && chan_en[c])); // R4
        AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (oc_latched[c] && chan_en[c]) |=> oc_latched[c]); // R6
        AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            !chan_en[c] |=> (!hs_block[c] && !oc_latched[c])); // R7
        AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (rst)
            (chan_en[c] && !cyc_start) |=> ($stable(hs_block[c]) && $stable(oc_latched[c]))); // R8
        AST_RESET_CLEAR: assert property (@(posedge clk)
            rst |=> (!hs_block[c] && !oc_latched[c])); // R10
    end
endmodule

bind ocp_guard ocp_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .lim_hit   (lim_hit),
    .chan_en   (chan_en),
    .hs_block  (hs_block),
    .oc_latched(oc_latched)
);

// File: tb/sim_ocp_guard.sv
module sim_ocp_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 2;
    localparam int SKIPN = 8;
    localparam int WATCHN = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cyc_start = 1'b0;
    logic [NCH-1:0] lim_hit = '0;
    logic [NCH-1:0] chan_en = '0;
    logic [NCH-1:0] hs_block;
    logic [NCH-1:0] oc_latched;

    ocp_guard #(.NUM_CH(NCH), .SKIP_CYC(SKIPN), .WATCH_CYC(WATCHN)) u0 (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .lim_hit(lim_hit),
        .chan_en(chan_en), .hs_block(hs_block), .oc_latched(oc_latched)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R10";
    bit    done = 1'b0;

    // reference model: mode 0 normal, 1 blocked, 2 watching, 3 latched
    int md [NCH];
    int ix [NCH];

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst || !chan_en[c]) begin
                md[c] = 0;
                ix[c] = 0;
            end else if (cyc_start) begin
                if (md[c] == 0) begin
                    if (lim_hit[c]) begin md[c] = 1; ix[c] = 0; end
                end else if (md[c] == 1 || md[c] == 2) begin
                    ix[c] = ix[c] + 1;
                    if (ix[c] > SKIPN) begin
                        if (lim_hit[c]) md[c] = 3;
                        else if (ix[c] == SKIPN + WATCHN) md[c] = 0;
                        else md[c] = 2;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            for (int c = 0; c < NCH; c++) begin
                logic eb, ef;
                eb = (md[c] == 1) || (md[c] == 3);
                ef = (md[c] == 3);
                n_chk++;
                if (hs_block[c] !== eb || oc_latched[c] !== ef) begin
                    n_err++;
                    $display("FAIL %s ch%0d model: block=%b latched=%b expected block=%b latched=%b",
                             tag, c, hs_block[c], oc_latched[c], eb, ef);
                end
            end
        end
    end

    task automatic chk(string t, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", t, act, exp);
        end
    endtask

    // one switching period of four clocks; limit flags forced high off-strobe
    task automatic period(bit l0, bit l1);
        @(negedge clk);
        cyc_start = 1'b1;
        lim_hit   = {l1, l0};
        @(negedge clk);
        cyc_start = 1'b0;
        lim_hit   = '1;
        repeat (2) @(negedge clk);
    endtask

    task automatic periods(int n, bit l0, bit l1);
        for (int i = 0; i < n; i++) period(l0, l1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 block after reset", hs_block[0], 1'b0);
        chk("R10 latched after reset", oc_latched[0], 1'b0);
        rst = 1'b0;
        chan_en = '1;

        tag = "R8";
        periods(3, 1'b0, 1'b0);
        chk("R8 off-strobe flag ignored", hs_block[0], 1'b0);

        tag = "R1";
        period(1'b1, 1'b0);
        chk("R1 trigger blocks", hs_block[0], 1'b1);
        chk("R9 other channel untouched", hs_block[1], 1'b0);

        tag = "R3";
        periods(2, 1'b0, 1'b0);
        period(1'b1, 1'b0);                 // period 3 hit ignored
        periods(4, 1'b0, 1'b0);
        period(1'b1, 1'b0);                 // period 8 hit ignored
        chk("R2 still blocked at period 8", hs_block[0], 1'b1);
        chk("R3 no fault from skip hits", oc_latched[0], 1'b0);
        tag = "R2";
        period(1'b0, 1'b0);                 // period 9
        chk("R2 released at period 9", hs_block[0], 1'b0);
        chk("R3 count not restarted", oc_latched[0], 1'b0);

        tag = "R5";
        periods(7, 1'b0, 1'b0);             // periods 10..16
        period(1'b1, 1'b0);                 // period 17: new trigger
        chk("R5 new interval at period 17", hs_block[0], 1'b1);
        chk("R5 no fault at period 17", oc_latched[0], 1'b0);

        tag = "R4";
        periods(8, 1'b0, 1'b0);
        period(1'b1, 1'b0);                 // period 9 hit
        chk("R4 fault at period 9", oc_latched[0], 1'b1);
        chk("R4 fault blocks", hs_block[0], 1'b1);

        tag = "R6";
        period(1'b1, 1'b1);                 // ch1 triggers while ch0 latched
        periods(2, 1'b0, 1'b0);
        chk("R6 fault holds", oc_latched[0], 1'b1);
        chk("R9 ch1 blocked independently", hs_block[1], 1'b1);
        chk("R9 ch1 not latched", oc_latched[1], 1'b0);

        tag = "R7";
        @(negedge clk); chan_en[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 disable clears fault", oc_latched[0], 1'b0);
        chk("R7 disable clears block", hs_block[0], 1'b0);
        period(1'b1, 1'b0);
        chk("R7 strobe ignored while disabled", hs_block[0], 1'b0);
        chk("R9 ch1 still blocked", hs_block[1], 1'b1);
        @(negedge clk); chan_en[0] = 1'b1;

        tag = "R4";
        period(1'b1, 1'b0);
        periods(8, 1'b0, 1'b0);
        periods(6, 1'b0, 1'b0);             // periods 9..14
        chk("R4 no fault before hit", oc_latched[0], 1'b0);
        period(1'b0, 1'b0);                 // 15
        period(1'b1, 1'b0);                 // 16 hit
        chk("R4 fault at period 16", oc_latched[0], 1'b1);

        tag = "R7";
        @(negedge clk); chan_en[0] = 1'b0;
        @(negedge clk); chan_en[0] = 1'b1;
        period(1'b1, 1'b0);                 // trigger
        periods(3, 1'b0, 1'b0);
        @(negedge clk); chan_en[0] = 1'b0;
        @(negedge clk); chan_en[0] = 1'b1;
        period(1'b0, 1'b0);
        chk("R7 disable inside skip returns to normal", hs_block[0], 1'b0);
        period(1'b1, 1'b0);
        periods(8, 1'b0, 1'b0);
        chk("R7 count restarted from zero", hs_block[0], 1'b1);
        period(1'b0, 1'b0);
        chk("R2 released after fresh count", hs_block[0], 1'b0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule